// File: doc/BRIEF.md
# Wormhole Virtual-Channel Input Controller

This block is the receiving end of one virtual channel in a wormhole-switched router. Flits come in from the link over a valid/ready handshake. Each flit carries a two-bit kind code in its top bits. The block keeps them in a small flit queue, much shorter than a packet. Buffer space and link bandwidth are taken one flit at a time. The channel itself belongs to a packet from the moment its opening flit is accepted until its closing flit leaves.

When an opening flit is stored, the block maps the destination field of that flit to an output port and raises a request toward the switch allocator. A grant from the allocator binds the channel to that port. After the grant, the queued flits are offered to the switch in arrival order, each one tagged with the bound port. Forwarding the closing flit releases the binding, and the channel then accepts a new packet. Flits that break the packet framing are taken off the link, discarded and reported.

Top module: `wvc_input`

## Requirements
- R1: During and right after reset the channel is idle: `in_ready` is 1, and `req_valid`, `out_valid` and `err` are 0.
- R2: Kind code in `in_flit[FLIT_W-1:FLIT_W-2]`: 2'b10 opens a packet, 2'b11 opens and closes a single-flit packet, 2'b00 is a body flit, 2'b01 closes a packet. An opening flit accepted while idle is queued, and from the next cycle `req_valid` is 1.
- R3: While a packet is open and its closing flit has not yet been accepted, `in_ready` equals "queue not full". With DEPTH flits queued, `in_ready` is 0.
- R4: A `grant` seen while `req_valid` is 1 makes the channel active in the next cycle. `grant` has no effect in any other state. While active, `out_valid` is 1 whenever the queue holds a flit, and `out_flit` presents the flits in arrival order, each one removed on `out_valid && out_ready`.
- R5: While active, `out_port` equals the `req_port` value held when the grant was taken, for every flit of the packet.
- R6: Once the closing flit of a packet has been accepted, `in_ready` stays 0 until the channel is idle again, so flits of two packets never share the queue.
- R7: After a flit of kind 2'b01 or 2'b11 is forwarded, the channel is idle in the next cycle: `out_valid` and `req_valid` are 0 and `in_ready` is 1.
- R8: `req_port` is the destination field `in_flit[DEST_W-1:0]` of the opening flit, modulo NUM_PORTS.
- R9: A body or closing flit offered while idle, or an opening flit offered while a packet is open, is accepted (`in_ready` is 1), is not queued, and raises `err` for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Link offers a flit |
| in_ready | output | 1 | Channel takes the offered flit |
| in_flit | input | FLIT_W | Flit: kind code in top two bits, destination in low DEST_W bits |
| req_valid | output | 1 | Packet waiting for an output |
| req_port | output | PORT_W | Output requested by the waiting packet |
| grant | input | 1 | Allocator grants the requested output |
| out_valid | output | 1 | A flit is offered to the switch |
| out_ready | input | 1 | Switch takes the offered flit |
| out_flit | output | FLIT_W | Oldest queued flit |
| out_port | output | PORT_W | Output bound to the current packet |
| err | output | 1 | Framing violation seen in the previous cycle |

## Verification
The hardest state to reach from the ports is a full queue before the grant: the packet still open, more body flits waiting on the link, and the closing flit arriving only after space frees. The stimulus reaches it by running in phases. In some phases grants are rare and the switch seldom takes flits, so packets pile up in the waiting state and push back on the link. In other phases both are frequent, so packets drain and re-arm quickly. Misframed flits are injected at a low rate and are driven from the reference model's idea of whether a packet is open. Every cycle, all outputs are compared with a queue-based model.

// File: rtl/wvc_pkg.sv
package wvc_pkg;
  // kind code: bit 1 = opens a packet, bit 0 = closes a packet
  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_TAIL = 2'b01,
    FK_HEAD = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  typedef enum logic [1:0] {
    VC_IDLE   = 2'd0,
    VC_WAIT   = 2'd1,
    VC_ACTIVE = 2'd2
  } vc_state_e;

  function automatic logic kind_opens(input logic [1:0] k);
    return k[1];
  endfunction

  function automatic logic kind_closes(input logic [1:0] k);
    return k[0];
  endfunction
endpackage

// File: rtl/wvc_route.sv
module wvc_route #(
  parameter int DEST_W    = 4,
  parameter int NUM_PORTS = 4,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic [DEST_W-1:0] dest,
  output logic [PORT_W-1:0] port
);
  logic [DEST_W-1:0] folded;

  always_comb begin
    folded = dest % DEST_W'(NUM_PORTS);
    port   = folded[PORT_W-1:0];
  end
endmodule

// File: rtl/wvc_fifo.sv
module wvc_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = count;
    if (push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop)      cnt_d = count + 1'b1;
    else if (pop && !push) cnt_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      count <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/wvc_fsm.sv
module wvc_fsm
  import wvc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acc,
  input  logic [1:0] kind,
  input  logic      grant,
  input  logic      pop_last,
  input  logic      full,
  output vc_state_e state,
  output logic      push,
  output logic      bad,
  output logic      open_head,
  output logic      take_grant,
  output logic      ready
);
  vc_state_e state_d;
  logic      closed_q, closed_d;

  always_comb begin
    open_head  = (state == VC_IDLE) && acc && kind_opens(kind);
    bad        = acc && ((state == VC_IDLE) != kind_opens(kind));
    push       = acc && !bad;
    take_grant = (state == VC_WAIT) && grant;
    ready      = (state == VC_IDLE) || (!closed_q && !full);

    state_d = state;
    unique case (state)
      VC_IDLE:   if (open_head)  state_d = VC_WAIT;
      VC_WAIT:   if (take_grant) state_d = VC_ACTIVE;
      VC_ACTIVE: if (pop_last)   state_d = VC_IDLE;
      default:                   state_d = VC_IDLE;
    endcase

    closed_d = closed_q;
    if (pop_last)                       closed_d = 1'b0;
    else if (push && kind_closes(kind)) closed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= VC_IDLE;
      closed_q <= 1'b0;
    end else begin
      state    <= state_d;
      closed_q <= closed_d;
    end
  end
endmodule

// File: rtl/wvc_input.sv
module wvc_input
  import wvc_pkg::*;
#(
  parameter int FLIT_W    = 16,
  parameter int DEPTH     = 2,
  parameter int DEST_W    = 4,
  parameter int NUM_PORTS = 4,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              req_valid,
  output logic [PORT_W-1:0] req_port,
  input  logic              grant,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_flit,
  output logic [PORT_W-1:0] out_port,
  output logic              err
);
  vc_state_e         state;
  logic              acc, push, pop, pop_last, bad, open_head, take_grant;
  logic              full, empty;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [PORT_W-1:0] route_port;
  logic [1:0]        in_kind;

  assign in_kind  = in_flit[FLIT_W-1 -: 2];
  assign acc      = in_valid && in_ready;
  assign pop      = out_valid && out_ready;
  assign pop_last = pop && kind_closes(out_flit[FLIT_W-1 -: 2]);

  wvc_route #(.DEST_W(DEST_W), .NUM_PORTS(NUM_PORTS)) u_route (
    .dest (in_flit[DEST_W-1:0]),
    .port (route_port)
  );

  wvc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .kind       (in_kind),
    .grant      (grant),
    .pop_last   (pop_last),
    .full       (full),
    .state      (state),
    .push       (push),
    .bad        (bad),
    .open_head  (open_head),
    .take_grant (take_grant),
    .ready      (in_ready)
  );

  wvc_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata (in_flit),
    .rdata (out_flit),
    .full  (full),
    .empty (empty),
    .count (fifo_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_port <= '0;
      out_port <= '0;
      err      <= 1'b0;
    end else begin
      if (open_head)  req_port <= route_port;
      if (take_grant) out_port <= req_port;
      err <= bad;
    end
  end

  assign req_valid = (state == VC_WAIT);
  assign out_valid = (state == VC_ACTIVE) && !empty;
endmodule

// File: rtl/wvc_input_chk.sv
module wvc_input_chk #(
  parameter int FLIT_W = 16,
  parameter int DEPTH  = 2,
  parameter int PORT_W = 2,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [FLIT_W-1:0] in_flit,
  input logic              req_valid,
  input logic              grant,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FLIT_W-1:0] out_flit,
  input logic [PORT_W-1:0] out_port,
  input logic              err,
  input logic [1:0]        state,
  input logic [CNT_W-1:0]  fifo_cnt
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CNT_W'(DEPTH)) |-> !in_ready);

  // R4
  req_out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && out_valid));

  // R4
  grant_activate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && grant) |=> (state == 2'd2));

  // R5
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_port));

  // R7
  tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_flit[FLIT_W-2]) |=> (state == 2'd0 && in_ready));

  // R2
  head_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && in_valid && in_ready && in_flit[FLIT_W-1]) |=> req_valid);

  // R9
  stray_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && in_valid && in_ready && !in_flit[FLIT_W-1]) |=> (err && fifo_cnt == '0));
endmodule

bind wvc_input wvc_input_chk #(
  .FLIT_W (FLIT_W),
  .DEPTH  (DEPTH),
  .PORT_W (PORT_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_flit   (in_flit),
  .req_valid (req_valid),
  .grant     (grant),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_flit  (out_flit),
  .out_port  (out_port),
  .err       (err),
  .state     (state),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/wvc_input_tb.sv
module wvc_input_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FLIT_W     = 16;
  localparam int DEPTH      = 2;
  localparam int DEST_W     = 4;
  localparam int NUM_PORTS  = 4;
  localparam int PORT_W     = $clog2(NUM_PORTS);
  localparam int CYCLES     = 6000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [FLIT_W-1:0] in_flit = '0;
  logic              req_valid;
  logic [PORT_W-1:0] req_port;
  logic              grant = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [FLIT_W-1:0] out_flit;
  logic [PORT_W-1:0] out_port;
  logic              err;

  int tests = 0;
  int fails = 0;

  // reference model: 0 idle, 1 waiting, 2 active
  logic [FLIT_W-1:0] q[$];
  int m_st = 0;
  bit m_closed = 0;
  int m_req = 0;
  int m_bind = 0;
  bit m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wvc_input #(.FLIT_W(FLIT_W), .DEPTH(DEPTH), .DEST_W(DEST_W), .NUM_PORTS(NUM_PORTS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .req_valid(req_valid), .req_port(req_port), .grant(grant), .out_valid(out_valid),
    .out_ready(out_ready), .out_flit(out_flit), .out_port(out_port), .err(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_ready();
    return (m_st == 0) || (!m_closed && q.size() < DEPTH);
  endfunction

  function automatic bit m_outv();
    return (m_st == 2) && (q.size() > 0);
  endfunction

  function automatic logic [FLIT_W-1:0] mk_flit(input logic [1:0] kind);
    logic [FLIT_W-1:0] f;
    f = FLIT_W'($urandom);
    f[FLIT_W-1 -: 2] = kind;
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit pending = 0;
    bit acc, pop;
    bit low_phase;
    logic [1:0] k;
    logic [FLIT_W-1:0] popped;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 in_ready", in_ready, 1);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready after release", in_ready, 1);
    chk("R1 out_valid after release", out_valid, 0);

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      low_phase = ((cyc / 250) % 2) == 1;
      // link side: hold an offered flit until it is taken
      if (!pending) begin
        if ($urandom_range(0, 99) < 80) begin
          int r = $urandom_range(0, 99);
          if (m_st != 0 && !m_closed)
            k = (r < 4) ? 2'b10 : (r < 70) ? 2'b00 : 2'b01;
          else
            k = (r < 6) ? 2'b00 : (r < 10) ? 2'b01 : (r < 75) ? 2'b10 : 2'b11;
          in_flit  = mk_flit(k);
          in_valid = 1'b1;
          pending  = 1;
        end else begin
          in_valid = 1'b0;
        end
      end
      grant     = ($urandom_range(0, 99) < (low_phase ? 5 : 60));
      out_ready = ($urandom_range(0, 99) < (low_phase ? 30 : 90));
      #1;

      // compare against the model
      chk("R3/R6/R7 in_ready", in_ready, m_ready());
      chk("R2 req_valid", req_valid, m_st == 1);
      if (m_st == 1) chk("R8 req_port", req_port, m_req);
      chk("R4 out_valid", out_valid, m_outv());
      if (m_outv()) begin
        chk("R4 out_flit order", out_flit, q[0]);
        chk("R5 out_port", out_port, m_bind);
      end
      chk("R9 err", err, m_err);

      // advance the model across the coming edge
      acc = in_valid && m_ready();
      pop = m_outv() && out_ready;
      m_err = 0;
      if (pop) begin
        popped = q.pop_front();
        if (popped[FLIT_W-2]) begin
          m_st = 0;
          m_closed = 0;
        end
      end
      if (acc) begin
        k = in_flit[FLIT_W-1 -: 2];
        if (m_st == 0 && !pop) begin
          if (k[1]) begin
            q.push_back(in_flit);
            m_req = int'(in_flit[DEST_W-1:0]) % NUM_PORTS;
            m_closed = k[0];
            m_st = 1;
          end else m_err = 1;
        end else begin
          if (k[1]) m_err = 1;
          else begin
            q.push_back(in_flit);
            if (k[0]) m_closed = 1;
          end
        end
        pending = 0;
      end
      if (m_st == 1 && grant && !(acc && k[1] && !m_err && q.size() == 1 && m_req >= 0 && 0)) begin
        if (!(acc && m_st == 1 && q.size() == 1 && k[1] && !m_err)) begin
          m_st = 2;
          m_bind = m_req;
        end
      end
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule